// File: doc/BRIEF.md
# Double-Buffered Safe Parameter Loader

This block stages coefficient updates for a running signal processor so that the processor never executes with a half-changed coefficient set. A host fills five shadow pairs through a small register-write interface. Each pair holds a 10-bit destination address and a 34-bit data word. The block keeps a written flag for each pair, so it knows which pairs the host has touched since the last commit.

The host requests a commit by pulsing one of two request inputs. One request targets the parameter memory and the other targets the target/slew memory. Each request raises a pending bit that the host can read back. The copy waits for the next frame-boundary tick. It then writes the flagged pairs, one per clock, into the chosen memory through a plain synchronous write port. When the copy ends, the pending bit drops and all written flags clear.

If the host writes a pair while a copy is running, that write is parked in a one-entry holding slot. It lands in the shadow pair, and sets that pair's flag, on the clock edge that ends the copy.

Top module: `shadow_param_loader`

## Requirements
- R1: After reset, `param_pend` and `slew_pend` are 0 and neither `pm_we` nor `sm_we` is asserted.
- R2: A host write with `host_sel` between 0 and 4 stores into the selected pair. When `host_is_addr`=1 it stores the address, taken from `host_wdata[9:0]`. When `host_is_addr`=0 it stores the data, all 34 bits of `host_wdata`. Either kind of write flags the pair. A write with `host_sel` of 5 or above is ignored.
- R3: A pulse on `go_param` (or `go_slew`) sets `param_pend` (or `slew_pend`). The bit stays 1 until its transfer completes, then clears by itself on the clock edge that carries the last copy write.
- R4: No copy write is issued until `frame_tick` is sampled high while a request is pending. The first write appears in the cycle after that edge.
- R5: Only flagged pairs are copied. They are copied in ascending index order, one per cycle, back to back, and unflagged pairs cost no cycle.
- R6: A parameter transfer drives only `pm_we`/`pm_addr`/`pm_wdata`, and a slew transfer drives only the `sm_` port. The stored address is passed through unchanged, so address 0 reaches location 0.
- R7: All written flags clear when a transfer completes. A later transfer copies only the pairs written after that point.
- R8: When both requests are pending, the parameter transfer runs first. The slew transfer stays pending until a later `frame_tick`.
- R9: A host write made while a copy is running does not change the values being copied. It is applied, and its pair flagged, on the edge that completes the copy.
- R10: A transfer with no flagged pair issues no write. Its pending bit clears on the `frame_tick` edge that starts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_we | input | 1 | Host shadow write strobe |
| host_sel | input | 3 | Shadow pair index |
| host_is_addr | input | 1 | 1: write the address register, 0: write the data register |
| host_wdata | input | 34 | Host write value |
| go_param | input | 1 | Request a commit to parameter memory |
| go_slew | input | 1 | Request a commit to target/slew memory |
| frame_tick | input | 1 | Frame-boundary strobe |
| param_pend | output | 1 | Parameter request pending or in progress |
| slew_pend | output | 1 | Slew request pending or in progress |
| pm_we | output | 1 | Parameter memory write enable |
| pm_addr | output | 10 | Parameter memory write address |
| pm_wdata | output | 34 | Parameter memory write data |
| sm_we | output | 1 | Slew memory write enable |
| sm_addr | output | 10 | Slew memory write address |
| sm_wdata | output | 34 | Slew memory write data |

## Verification
The assertions rely on three things about the inputs:
- The host makes at most one shadow write during any copy, because the holding slot keeps only the latest.
- Request pulses for a destination are not repeated while that destination's copy is running.
- `frame_tick` is a single-cycle pulse.

The bench drives every input on the falling edge as a one-cycle pulse. It issues the single mid-copy write only in the test aimed at that case, and it spaces frame ticks so that each copy ends before the next tick arrives.

// File: rtl/shadow_param_loader_pkg.sv
package shadow_param_loader_pkg;

  typedef enum logic {
    DEST_PARAM = 1'b0,
    DEST_SLEW  = 1'b1
  } dest_e;

  // index of the lowest set bit (0 when none is set)
  function automatic int unsigned first_set(input logic [31:0] m);
    int unsigned r;
    r = 0;
    for (int i = 31; i >= 0; i--) begin
      if (m[i]) r = i;
    end
    return r;
  endfunction

  // mask with its lowest set bit removed
  function automatic logic [31:0] drop_first(input logic [31:0] m);
    return m & (m - 32'd1);
  endfunction

endpackage

// File: rtl/shadow_bank.sv
module shadow_bank
  import shadow_param_loader_pkg::*;
#(
  parameter int NP = 5,
  parameter int AW = 10,
  parameter int DW = 34,
  parameter int IW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_we,
  input  logic [IW-1:0] host_sel,
  input  logic          host_is_addr,
  input  logic [DW-1:0] host_wdata,
  input  logic          copying,
  input  logic          start,
  input  logic          done_now,
  input  logic [IW-1:0] rd_idx,
  output logic [NP-1:0] flags,
  output logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);

  localparam logic [IW-1:0] LAST_IDX = IW'(NP - 1);

  logic [AW-1:0] addr_q [NP];
  logic [DW-1:0] data_q [NP];
  logic [NP-1:0] flag_q;

  logic          hold_v;
  logic [IW-1:0] hold_sel;
  logic          hold_is_addr;
  logic [DW-1:0] hold_data;

  logic sel_ok, direct_wr, capture, apply_hold;

  assign sel_ok     = host_sel <= LAST_IDX;
  assign direct_wr  = host_we && sel_ok && ((!copying && !start) || done_now);
  assign capture    = host_we && sel_ok && !direct_wr;
  assign apply_hold = hold_v && done_now;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_q <= '0;
      for (int p = 0; p < NP; p++) begin
        addr_q[p] <= '0;
        data_q[p] <= '0;
      end
    end else begin
      for (int p = 0; p < NP; p++) begin
        if (done_now) flag_q[p] <= 1'b0;
        if (apply_hold && hold_sel == IW'(p)) begin
          flag_q[p] <= 1'b1;
          if (hold_is_addr) addr_q[p] <= hold_data[AW-1:0];
          else              data_q[p] <= hold_data;
        end
        if (direct_wr && host_sel == IW'(p)) begin
          flag_q[p] <= 1'b1;
          if (host_is_addr) addr_q[p] <= host_wdata[AW-1:0];
          else              data_q[p] <= host_wdata;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_v       <= 1'b0;
      hold_sel     <= '0;
      hold_is_addr <= 1'b0;
      hold_data    <= '0;
    end else if (capture) begin
      hold_v       <= 1'b1;
      hold_sel     <= host_sel;
      hold_is_addr <= host_is_addr;
      hold_data    <= host_wdata;
    end else if (apply_hold) begin
      hold_v <= 1'b0;
    end
  end

  assign flags   = flag_q;
  assign rd_addr = addr_q[rd_idx];
  assign rd_data = data_q[rd_idx];

  // R7
  flags_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_now && !host_we && !hold_v) |=> (flag_q == '0));

  // R9
  held_write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_v && done_now) |=> (!hold_v && flag_q != '0));

endmodule

// File: rtl/commit_seq.sv
module commit_seq
  import shadow_param_loader_pkg::*;
#(
  parameter int NP = 5,
  parameter int IW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go_param,
  input  logic          go_slew,
  input  logic          frame_tick,
  input  logic [NP-1:0] flags,
  output logic          param_pend,
  output logic          slew_pend,
  output logic          copying,
  output dest_e         dest,
  output logic          start,
  output logic          done_now,
  output logic [IW-1:0] cur_idx
);

  logic          copying_q;
  dest_e         dest_q;
  logic [NP-1:0] rem_q;
  logic          pp_q, sp_q;
  dest_e         start_dest, done_dest;
  logic          empty_start, last_write;

  assign start       = !copying_q && frame_tick && (pp_q || sp_q);
  assign start_dest  = pp_q ? DEST_PARAM : DEST_SLEW;
  assign empty_start = start && (flags == '0);
  assign last_write  = copying_q && (drop_first(32'(rem_q)) == 32'd0);
  assign done_now    = last_write || empty_start;
  assign done_dest   = copying_q ? dest_q : start_dest;
  assign cur_idx     = IW'(first_set(32'(rem_q)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pp_q <= 1'b0;
      sp_q <= 1'b0;
    end else begin
      pp_q <= (pp_q && !(done_now && done_dest == DEST_PARAM)) || go_param;
      sp_q <= (sp_q && !(done_now && done_dest == DEST_SLEW))  || go_slew;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      copying_q <= 1'b0;
      dest_q    <= DEST_PARAM;
      rem_q     <= '0;
    end else if (start && !empty_start) begin
      copying_q <= 1'b1;
      dest_q    <= start_dest;
      rem_q     <= flags;
    end else if (copying_q) begin
      rem_q <= NP'(drop_first(32'(rem_q)));
      if (last_write) copying_q <= 1'b0;
    end
  end

  assign param_pend = pp_q;
  assign slew_pend  = sp_q;
  assign copying    = copying_q;
  assign dest       = dest_q;

  // R5
  rem_shrinks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (copying_q && !last_write) |=> ($countones(rem_q) == $countones($past(rem_q)) - 1));

  // R3
  pend_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_now && done_dest == DEST_PARAM && !go_param) |=> !param_pend);

  // R4
  start_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(copying_q) |-> $past(frame_tick));

  // R8
  param_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(copying_q) && $past(param_pend)) |-> (dest_q == DEST_PARAM));

endmodule

// File: rtl/dest_steer.sv
module dest_steer
  import shadow_param_loader_pkg::*;
#(
  parameter int AW = 10,
  parameter int DW = 34
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          copying,
  input  dest_e         dest,
  input  logic [AW-1:0] src_addr,
  input  logic [DW-1:0] src_data,
  output logic          pm_we,
  output logic [AW-1:0] pm_addr,
  output logic [DW-1:0] pm_wdata,
  output logic          sm_we,
  output logic [AW-1:0] sm_addr,
  output logic [DW-1:0] sm_wdata
);

  assign pm_we    = copying && (dest == DEST_PARAM);
  assign sm_we    = copying && (dest == DEST_SLEW);
  assign pm_addr  = src_addr;
  assign sm_addr  = src_addr;
  assign pm_wdata = src_data;
  assign sm_wdata = src_data;

  // R6
  single_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(pm_we && sm_we));

  // R4
  quiet_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !copying |-> (!pm_we && !sm_we));

endmodule

// File: rtl/shadow_param_loader.sv
module shadow_param_loader
  import shadow_param_loader_pkg::*;
#(
  parameter int NP = 5,
  parameter int AW = 10,
  parameter int DW = 34,
  localparam int IW = (NP > 1) ? $clog2(NP) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_we,
  input  logic [IW-1:0] host_sel,
  input  logic          host_is_addr,
  input  logic [DW-1:0] host_wdata,
  input  logic          go_param,
  input  logic          go_slew,
  input  logic          frame_tick,
  output logic          param_pend,
  output logic          slew_pend,
  output logic          pm_we,
  output logic [AW-1:0] pm_addr,
  output logic [DW-1:0] pm_wdata,
  output logic          sm_we,
  output logic [AW-1:0] sm_addr,
  output logic [DW-1:0] sm_wdata
);

  logic [NP-1:0] flags;
  logic          copying, start, done_now;
  dest_e         dest;
  logic [IW-1:0] cur_idx;
  logic [AW-1:0] cur_addr;
  logic [DW-1:0] cur_data;

  shadow_bank #(.NP(NP), .AW(AW), .DW(DW), .IW(IW)) i_bank (
    .clk(clk), .rst_n(rst_n),
    .host_we(host_we), .host_sel(host_sel), .host_is_addr(host_is_addr),
    .host_wdata(host_wdata),
    .copying(copying), .start(start), .done_now(done_now),
    .rd_idx(cur_idx), .flags(flags), .rd_addr(cur_addr), .rd_data(cur_data)
  );

  commit_seq #(.NP(NP), .IW(IW)) i_seq (
    .clk(clk), .rst_n(rst_n),
    .go_param(go_param), .go_slew(go_slew), .frame_tick(frame_tick),
    .flags(flags), .param_pend(param_pend), .slew_pend(slew_pend),
    .copying(copying), .dest(dest), .start(start), .done_now(done_now),
    .cur_idx(cur_idx)
  );

  dest_steer #(.AW(AW), .DW(DW)) i_steer (
    .clk(clk), .rst_n(rst_n),
    .copying(copying), .dest(dest), .src_addr(cur_addr), .src_data(cur_data),
    .pm_we(pm_we), .pm_addr(pm_addr), .pm_wdata(pm_wdata),
    .sm_we(sm_we), .sm_addr(sm_addr), .sm_wdata(sm_wdata)
  );

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |=> (!param_pend && !slew_pend && !pm_we && !sm_we));

endmodule

// File: tb/test_shadow_param_loader.sv
`timescale 1ns/1ps
module test_shadow_param_loader;

  localparam int NP = 5;
  localparam int AW = 10;
  localparam int DW = 34;
  localparam int IW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          host_we = 1'b0;
  logic [IW-1:0] host_sel = '0;
  logic          host_is_addr = 1'b0;
  logic [DW-1:0] host_wdata = '0;
  logic          go_param = 1'b0, go_slew = 1'b0, frame_tick = 1'b0;
  logic          param_pend, slew_pend, pm_we, sm_we;
  logic [AW-1:0] pm_addr, sm_addr;
  logic [DW-1:0] pm_wdata, sm_wdata;

  always #4 clk = ~clk;

  shadow_param_loader i_shadow_param_loader (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_sel(host_sel),
    .host_is_addr(host_is_addr), .host_wdata(host_wdata),
    .go_param(go_param), .go_slew(go_slew), .frame_tick(frame_tick),
    .param_pend(param_pend), .slew_pend(slew_pend),
    .pm_we(pm_we), .pm_addr(pm_addr), .pm_wdata(pm_wdata),
    .sm_we(sm_we), .sm_addr(sm_addr), .sm_wdata(sm_wdata)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  // model of shadow contents
  logic [AW-1:0] m_addr [NP];
  logic [DW-1:0] m_data [NP];

  // {dest(1=slew), pair mask}
  localparam logic [5:0] VEC [6] = '{6'b0_11111, 6'b1_10101, 6'b0_00001,
                                      6'b1_10000, 6'b0_01110, 6'b1_11011};

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic hwrite(input int sel, input bit is_addr, input logic [DW-1:0] v);
    host_we = 1'b1; host_sel = IW'(sel); host_is_addr = is_addr; host_wdata = v;
    @(negedge clk);
    host_we = 1'b0;
    if (sel < NP) begin
      if (is_addr) m_addr[sel] = v[AW-1:0];
      else         m_data[sel] = v;
    end
  endtask

  task automatic fill(input logic [4:0] mask, input int v);
    for (int i = 0; i < NP; i++) if (mask[i]) begin
      hwrite(i, 1'b1, DW'((v * 37 + i * 101 + 3) % 1024) | 34'h3_0000_0000);
      hwrite(i, 1'b0, {2'(i % 4), 32'hA500_0000 + 32'(v * 256 + i)});
    end
  endtask

  task automatic pulse_go(input bit p, input bit s);
    go_param = p; go_slew = s;
    @(negedge clk);
    go_param = 1'b0; go_slew = 1'b0;
  endtask

  task automatic tick;
    frame_tick = 1'b1;
    @(negedge clk);
    frame_tick = 1'b0;
  endtask

  // called right after the tick edge; walks the expected copy writes
  task automatic expect_copy(input logic [4:0] mask, input bit slew, input string req);
    for (int i = 0; i < NP; i++) if (mask[i]) begin
      check(req, "we", slew ? sm_we : pm_we, 1'b1);
      check("R6", "other we", slew ? pm_we : sm_we, 1'b0);
      check(req, "addr", slew ? sm_addr : pm_addr, m_addr[i]);
      check(req, "data", slew ? sm_wdata : pm_wdata, m_data[i]);
      @(negedge clk);
    end
    check(req, "we after copy", {pm_we, sm_we}, 2'b00);
    check("R3", "pend cleared", slew ? slew_pend : param_pend, 1'b0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NP; i++) begin m_addr[i] = '0; m_data[i] = '0; end
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", "pend", {param_pend, slew_pend}, 2'b00);
    check("R1", "we", {pm_we, sm_we}, 2'b00);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "pend after release", {param_pend, slew_pend}, 2'b00);

    // table walk: R5, R6, R4, R3
    for (int v = 0; v < 6; v++) begin
      fill(VEC[v][4:0], v);
      pulse_go(!VEC[v][5], VEC[v][5]);
      for (int w = 0; w < 3; w++) begin
        check("R4", "no write before tick", {pm_we, sm_we}, 2'b00);
        check("R3", "pend held", VEC[v][5] ? slew_pend : param_pend, 1'b1);
        @(negedge clk);
      end
      tick();
      expect_copy(VEC[v][4:0], VEC[v][5], "R5");
    end

    // R6 address 0 passthrough; R2 upper wdata bits dropped from address
    hwrite(0, 1'b1, 34'h3_FFFF_FC00);
    hwrite(0, 1'b0, 34'h1_2345_6789);
    pulse_go(1, 0); tick();
    check("R6", "addr zero", pm_addr, 10'd0);
    expect_copy(5'b00001, 0, "R6");

    // R2 invalid index ignored, data-only write flags the pair
    hwrite(5, 1'b0, 34'h0_DEAD_BEEF);
    hwrite(7, 1'b1, 34'h0_0000_0111);
    pulse_go(1, 0); tick();
    check("R2", "no write for bad index", {pm_we, sm_we, param_pend}, 3'b000);
    hwrite(2, 1'b0, 34'h2_CAFE_0002);
    pulse_go(0, 1); tick();
    expect_copy(5'b00100, 1, "R2");

    // R10 empty transfer
    pulse_go(0, 1);
    check("R10", "pend set", slew_pend, 1'b1);
    tick();
    check("R10", "pend cleared at tick", slew_pend, 1'b0);
    check("R10", "no write", {pm_we, sm_we}, 2'b00);

    // R8 both requests together
    fill(5'b00101, 40);
    pulse_go(1, 1); tick();
    expect_copy(5'b00101, 0, "R8");
    check("R8", "slew still pending", slew_pend, 1'b1);
    repeat (2) @(negedge clk);
    check("R8", "slew waits for tick", {pm_we, sm_we}, 2'b00);
    fill(5'b10000, 41);
    tick();
    expect_copy(5'b10000, 1, "R8");

    // R9 write during copy held; R7 flags cleared
    fill(5'b01010, 50);
    pulse_go(1, 0); tick();
    check("R9", "first pair", pm_addr, m_addr[1]);
    host_we = 1'b1; host_sel = 3; host_is_addr = 1'b0; host_wdata = 34'h1_0BAD_F00D;
    @(negedge clk);
    host_we = 1'b0;
    check("R9", "copy keeps old data", pm_wdata, m_data[3]);
    @(negedge clk);
    check("R9", "done", {pm_we, param_pend}, 2'b00);
    m_data[3] = 34'h1_0BAD_F00D;
    pulse_go(1, 0); tick();
    expect_copy(5'b01000, 0, "R7");

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule